// File: doc/BRIEF.md
# Circular Double-Buffer DMA Channel

This block is a single DMA channel that moves data items from a peripheral into memory, alternating between two memory buffers. Software programs two buffer base addresses and an item count, then sets the enable bit. Each peripheral request is served in the same cycle: the channel acknowledges it and issues one memory write at the active buffer base plus the running byte offset.

When the count of the current transaction runs out, the channel switches to the other buffer, reloads the count and raises a transfer-complete event. It then continues on its own, so a second agent can drain one buffer while the channel fills the other. The channel only stops when the enable bit is cleared. The transfer-complete flag stays set until an agent writes the channel's flag mask to the clear register.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the channel is disabled, the flag, the pulse and the buffer-select bit are 0, and no acknowledge or memory write is issued even when a request is present.
- R2: While enabled with a nonzero remaining count, a high `per_req` gives `per_ack` and `mem_we` in the same cycle, with `mem_wdata` equal to `per_data`. Each such item decrements the remaining count by one. With `per_req` low nothing moves.
- R3: The memory address of an item is the active buffer base plus ITEM_BYTES times the item's index within the current transaction. Buffer 0 uses the base at register offset 2 and buffer 1 the base at offset 3.
- R4: The item that brings the count to zero ends the transaction. Its successor uses the other buffer at offset zero, and the remaining count is reloaded from the reload register at offset 1.
- R5: The channel cycles between the buffers without stopping until enable (bit 0 of offset 0) is written 0. Writing enable from 0 to 1 restarts at buffer 0 with the full count.
- R6: Each end of transaction sets `tc_flag` and drives `tc_out` high for exactly the one cycle after the last item.
- R7: A write to offset 4 with bit TC_BIT (default 0) set clears the flag in the next cycle. A write to offset 4 without that bit leaves the flag unchanged.
- R8: If a clear write and an end of transaction fall in the same cycle, the flag stays set.
- R9: Disabling the channel after at least one item of the current transaction has moved raises `tc_out` and sets the flag. Disabling at a transaction boundary does neither.
- R10: With a reload value of 0 the enabled channel moves no items.
- R11: Reads are combinational. Offset 0 returns enable in bit 0, buffer select in bit 1 and the flag in bit 2. Offsets 1, 2 and 3 return the reload value and the two bases. Offset 5 returns the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 1 | Peripheral item request |
| per_ack | output | 1 | Item accepted this cycle |
| per_data | input | DATA_W | Peripheral item data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| tc_out | output | 1 | One-cycle transfer-complete pulse |
| tc_flag | output | 1 | Sticky transfer-complete flag |

## Verification
A wrong buffer-select bit or byte offset shows up at `mem_addr` on the very next acknowledged item. A miscounted remaining count shows up at the transaction boundary: `tc_out` is misplaced by a cycle or more, and so is the switch to the other base. Flag corruption appears on the read port one cycle after the offending clear or completion. For that reason the bench checks every item address, the pulse cycle after each item, and the read port directly after each control write.

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int ITEM_BYTES = 2,
  parameter int TC_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [DATA_W-1:0] per_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              tc_out,
  output logic              tc_flag
);
  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_RELOAD = 3'd1;
  localparam logic [2:0] RA_BASE0  = 3'd2;
  localparam logic [2:0] RA_BASE1  = 3'd3;
  localparam logic [2:0] RA_CLEAR  = 3'd4;
  localparam logic [2:0] RA_COUNT  = 3'd5;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ITEM_BYTES);

  logic              en, sel;
  logic [CNT_W-1:0]  reload, cnt;
  logic [ADDR_W-1:0] base0, base1, offset;

  wire wr_ctrl = reg_wr && reg_addr == RA_CTRL;
  wire en_rise = wr_ctrl && reg_wdata[0] && !en;
  wire en_fall = wr_ctrl && !reg_wdata[0] && en;
  wire xfer    = en && per_req && cnt != '0;
  wire eot     = xfer && cnt == CNT_W'(1);
  wire abort   = en_fall && !eot && (offset != '0 || xfer);
  wire tc_set  = eot || abort;
  wire clr     = reg_wr && reg_addr == RA_CLEAR && reg_wdata[TC_BIT];

  assign per_ack   = xfer;
  assign mem_we    = xfer;
  assign mem_wdata = per_data;
  assign mem_addr  = (sel ? base1 : base0) + offset;

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = {29'd0, tc_flag, sel, en};
      RA_RELOAD: reg_rdata = 32'(reload);
      RA_BASE0:  reg_rdata = 32'(base0);
      RA_BASE1:  reg_rdata = 32'(base1);
      RA_COUNT:  reg_rdata = 32'(cnt);
      default:   reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      sel     <= 1'b0;
      reload  <= '0;
      cnt     <= '0;
      base0   <= '0;
      base1   <= '0;
      offset  <= '0;
      tc_flag <= 1'b0;
      tc_out  <= 1'b0;
    end else begin
      if (wr_ctrl) en <= reg_wdata[0];
      if (reg_wr && reg_addr == RA_RELOAD) reload <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == RA_BASE0)  base0  <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && reg_addr == RA_BASE1)  base1  <= reg_wdata[ADDR_W-1:0];
      if (en_rise) begin
        cnt    <= reload;
        sel    <= 1'b0;
        offset <= '0;
      end else if (eot) begin
        cnt    <= reload;
        sel    <= ~sel;
        offset <= '0;
      end else if (xfer) begin
        cnt    <= cnt - CNT_W'(1);
        offset <= offset + STEP;
      end
      if (tc_set)   tc_flag <= 1'b1;
      else if (clr) tc_flag <= 1'b0;
      tc_out <= tc_set;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !tc_out && !tc_flag && !per_ack);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack && cnt > CNT_W'(1) && !en_rise |=> cnt == $past(cnt) - CNT_W'(1));

  p_offset_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack && !eot |=> offset == $past(offset) + STEP);

  p_swap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eot && !(reg_wr && reg_addr == RA_RELOAD) |=>
      sel != $past(sel) && cnt == $past(reload) && offset == '0);

  p_stays_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wr_ctrl |=> en);

  p_tc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> tc_out && tc_flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !tc_set |=> !tc_flag);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && eot |=> tc_flag);

  p_no_move_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 |-> !per_ack);
endmodule

// File: tb/dbuf_dma_chan_bench.sv
`timescale 1ns/100ps
module dbuf_dma_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic [15:0] per_data = 16'd0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        tc_out, tc_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbuf_dma_chan u_dbuf_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .per_ack(per_ack), .per_data(per_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tc_out(tc_out),
    .tc_flag(tc_flag));

  // {end-of-transaction, expected address}; reload 3, bases 0x100 / 0x200, 2-byte items
  localparam logic [16:0] VEC [7] = '{
    {1'b0, 16'h0100}, {1'b0, 16'h0102}, {1'b1, 16'h0104},
    {1'b0, 16'h0200}, {1'b0, 16'h0202}, {1'b1, 16'h0204},
    {1'b0, 16'h0100}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd0;
    #0.5;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic item(input logic [15:0] d);
    @(negedge clk);
    per_req = 1'b1; per_data = d;
    @(negedge clk);
    per_req = 1'b0;
    #0.5;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    per_req = 1'b1;
    rst_n = 1'b1;
    #0.5;
    chk("R1 ack while disabled", {31'd0, per_ack}, 32'd0);
    chk("R1 write while disabled", {31'd0, mem_we}, 32'd0);
    chk("R1 pulse", {31'd0, tc_out}, 32'd0);
    rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
    per_req = 1'b0;

    wr(3'd1, 32'd3);
    wr(3'd2, 32'h100);
    wr(3'd3, 32'h200);
    rd(3'd1, v); chk("R11 reload readback", v, 32'd3);
    rd(3'd2, v); chk("R11 base0 readback", v, 32'h100);
    rd(3'd3, v); chk("R11 base1 readback", v, 32'h200);
    wr(3'd0, 32'd1);
    rd(3'd0, v); chk("R5 enabled buffer0", v, 32'd1);
    rd(3'd5, v); chk("R5 full count", v, 32'd3);

    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      per_req = 1'b1; per_data = 16'hA000 + 16'(i);
      #0.5;
      chk("R2 ack", {31'd0, per_ack}, 32'd1);
      chk("R2 mem write", {31'd0, mem_we}, 32'd1);
      chk("R2 data", 32'(mem_wdata), 32'hA000 + i);
      chk("R3 R4 address", 32'(mem_addr), 32'(VEC[i][15:0]));
      @(negedge clk);
      per_req = 1'b0;
      #0.5;
      chk("R6 pulse", {31'd0, tc_out}, {31'd0, VEC[i][16]});
      if (VEC[i][16]) chk("R6 flag", {31'd0, tc_flag}, 32'd1);
      @(negedge clk);
      #0.5;
      chk("R6 pulse one cycle", {31'd0, tc_out}, 32'd0);
    end
    rd(3'd5, v); chk("R4 count after reload", v, 32'd2);
    rd(3'd0, v); chk("R5 cycling, buffer0 flag set", v, 32'h5);

    @(negedge clk); #0.5;
    chk("R2 idle no ack", {31'd0, per_ack}, 32'd0);
    rd(3'd5, v); chk("R2 idle count held", v, 32'd2);

    wr(3'd4, 32'h2);
    chk("R7 wrong bit keeps flag", {31'd0, tc_flag}, 32'd1);
    wr(3'd4, 32'h1);
    chk("R7 clear", {31'd0, tc_flag}, 32'd0);

    item(16'h1111);
    rd(3'd5, v); chk("R2 count to one", v, 32'd1);
    @(negedge clk);
    per_req = 1'b1; per_data = 16'h2222;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
    #0.5;
    chk("R3 last address", 32'(mem_addr), 32'h104);
    @(negedge clk);
    per_req = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0;
    #0.5;
    chk("R8 flag stays set", {31'd0, tc_flag}, 32'd1);
    chk("R8 pulse", {31'd0, tc_out}, 32'd1);

    wr(3'd4, 32'h1);
    wr(3'd0, 32'd0);
    chk("R9 boundary no pulse", {31'd0, tc_out}, 32'd0);
    chk("R9 boundary no flag", {31'd0, tc_flag}, 32'd0);
    @(negedge clk);
    per_req = 1'b1; #0.5;
    chk("R5 disabled no ack", {31'd0, per_ack}, 32'd0);
    per_req = 1'b0;

    wr(3'd0, 32'd1);
    rd(3'd0, v); chk("R5 restart buffer0", v, 32'd1);
    rd(3'd5, v); chk("R5 restart count", v, 32'd3);
    item(16'h3333);
    wr(3'd0, 32'd0);
    chk("R9 mid pulse", {31'd0, tc_out}, 32'd1);
    chk("R9 mid flag", {31'd0, tc_flag}, 32'd1);

    wr(3'd1, 32'd0);
    wr(3'd0, 32'd1);
    @(negedge clk);
    per_req = 1'b1; #0.5;
    chk("R10 zero reload no ack", {31'd0, per_ack}, 32'd0);
    chk("R10 zero reload no write", {31'd0, mem_we}, 32'd0);
    per_req = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule